// File: doc/BRIEF.md
# Register Bus Address-Space Splitter

This block fans one upstream register bus out to a parameterised number of downstream register buses. The upstream side carries a read strobe, a write strobe, a 16-bit address, 32-bit write data and a timeout flag. It receives back 32-bit read data and four reply flags: dataready, write acknowledge, no-more-data and unknown-address. Every downstream port carries the same signal set and the same timing, so a register block can sit behind a port exactly as it would sit on the upstream bus.

Each port owns a window of 2**m consecutive addresses that starts at its base address. Both the base and the width m are parameters of that port. A strobe is passed, in the same cycle, to the single port whose window holds the address. The splitter then remembers that port and routes only that port's replies and read data upstream until the port answers or the upstream side signals a timeout. An address that falls in no window is refused by the splitter itself with unknown-address.

Top module: `regbus_split`

## Requirements
- R1: Port i matches an address when the address bits above bit m_i equal the same bits of that port's base address. The default configuration is port 0 = 0xA000 with m = 4, port 1 = 0x8000 with m = 6, and port 2 = 0xA000 with m = 8. Port 1 therefore covers 0x8000..0x803F, and 0x8040 matches no port.
- R2: A read or write strobe appears on the matching port in the same cycle, together with the address and write data. Every other port sees zero on its strobes, its address and its write data. A port that is not strobed sees address and data of zero.
- R3: When several windows match, the port with the lowest index takes the access. With the default configuration, 0xA005 goes to port 0 and 0xA0F0 goes to port 2.
- R4: A strobe whose address matches no port reaches no port. It is answered upstream with unknown-address high for exactly one cycle, in the cycle after the strobe.
- R5: From the cycle after a strobe, the dataready, write-acknowledge, no-more-data and unknown-address flags of the selected port appear upstream in the same cycle they are raised.
- R6: While an access is outstanding, reply flags and read data from every other port have no effect upstream. With no access outstanding, no downstream reply reaches the upstream side.
- R7: The outstanding access ends after any reply flag from the selected port, or after an upstream timeout. Later replies from that port are ignored. A new strobe replaces the outstanding access.
- R8: The upstream timeout is passed, in the same cycle, only to the port that holds the outstanding access. With nothing outstanding, no port sees it.
- R9: Upstream read data equals the selected port's read data in a cycle where that port's dataready reaches the upstream side. In every other cycle it is zero.
- R10: A synchronous active-high reset clears the outstanding access and the pending refusal. All upstream replies and read data are then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_rd | input | 1 | Upstream read strobe |
| up_wr | input | 1 | Upstream write strobe |
| up_addr | input | 16 | Upstream address |
| up_wdata | input | 32 | Upstream write data |
| up_timeout | input | 1 | Upstream gives up on the outstanding access |
| up_rdata | output | 32 | Read data returned upstream |
| up_dataready | output | 1 | Read data valid |
| up_write_ack | output | 1 | Write accepted |
| up_no_more_data | output | 1 | Target has no further data or cannot take more |
| up_unknown_addr | output | 1 | Address refused |
| dn_rd | output | NPORT | Per-port read strobe |
| dn_wr | output | NPORT | Per-port write strobe |
| dn_addr | output | NPORT*16 | Per-port address, port i at bits 16i+15..16i |
| dn_wdata | output | NPORT*32 | Per-port write data, port i at bits 32i+31..32i |
| dn_timeout | output | NPORT | Per-port timeout |
| dn_rdata | input | NPORT*32 | Per-port read data, port i at bits 32i+31..32i |
| dn_dataready | input | NPORT | Per-port dataready |
| dn_write_ack | input | NPORT | Per-port write acknowledge |
| dn_no_more_data | input | NPORT | Per-port no-more-data |
| dn_unknown_addr | input | NPORT | Per-port unknown-address |

## Verification
The bench targets the window edges (0x803F against 0x8040, 0xA0FF against 0xA100), where an off-by-one in the mask compare would strobe the wrong port or none at all. It also targets the overlap of ports 0 and 2, where a wrong priority order would send 0xA005 to port 2. Replies raised by a port that does not hold the access, replies raised after the access has closed, and a timeout raised with nothing outstanding must all stay invisible. A design that forgot the owner, or never closed the access, would leak those replies upstream or pass the timeout to the wrong port. A long random phase mixes strobes, stray replies and timeouts against a behavioural model, so the one-cycle refusal timing and the rule that read data is zero outside dataready are checked on every clock.

// File: rtl/regbus_split_pkg.sv
package regbus_split_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int MASKW_W = 5;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [MASKW_W-1:0] maskw_t;

    // handshake flags returned by a register target
    typedef struct packed {
        logic dataready;
        logic write_ack;
        logic no_more_data;
        logic unknown_addr;
    } reply_t;

    // address lies in the 2**mw window that starts at base
    function automatic logic in_window(addr_t a, addr_t base, maskw_t mw);
        return (a >> mw) == (base >> mw);
    endfunction

    function automatic logic reply_any(reply_t r);
        return r.dataready | r.write_ack | r.no_more_data | r.unknown_addr;
    endfunction

endpackage

// File: rtl/regbus_split_decode.sv
module regbus_split_decode
    import regbus_split_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int IDX_W = 2,
    parameter logic [NPORT-1:0][ADDR_W-1:0]  PORT_BASE = '0,
    parameter logic [NPORT-1:0][MASKW_W-1:0] PORT_MW   = '0
) (
    input  addr_t            addr,
    output logic [NPORT-1:0] hit_onehot,
    output logic [IDX_W-1:0] hit_idx,
    output logic             any_hit
);

    logic [NPORT-1:0] raw_hit;

    genvar g;
    for (g = 0; g < NPORT; g++) begin : g_win
        assign raw_hit[g] = in_window(addr, PORT_BASE[g], PORT_MW[g]);
    end

    // lowest index wins
    always_comb begin
        hit_idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (raw_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_onehot = raw_hit & (~raw_hit + NPORT'(1));
    assign any_hit    = |raw_hit;

endmodule

// File: rtl/regbus_split_track.sv
module regbus_split_track
    import regbus_split_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             any_hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  reply_t           cur_reply,
    input  logic             up_timeout,
    output logic             pend_valid,
    output logic [IDX_W-1:0] pend_idx,
    output logic             nomatch_q
);

    logic done;
    assign done = reply_any(cur_reply) | up_timeout;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_idx   <= '0;
            nomatch_q  <= 1'b0;
        end else if (strobe) begin
            pend_valid <= any_hit;
            pend_idx   <= hit_idx;
            nomatch_q  <= ~any_hit;
        end else begin
            nomatch_q  <= 1'b0;
            if (pend_valid && done) pend_valid <= 1'b0;
        end
    end

    // R7: an open access keeps its owner while nothing closes it
    p_hold_owner_r7: assert property (@(posedge clk) disable iff (rst)
        pend_valid && !reply_any(cur_reply) && !up_timeout && !strobe
        |=> pend_valid && $stable(pend_idx));

    // R7: an answer or a timeout closes the access
    p_close_r7: assert property (@(posedge clk) disable iff (rst)
        pend_valid && (reply_any(cur_reply) || up_timeout) && !strobe
        |=> !pend_valid);

endmodule

// File: rtl/regbus_split_route.sv
module regbus_split_route
    import regbus_split_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int IDX_W = 2
) (
    input  logic                         pend_valid,
    input  logic [IDX_W-1:0]             pend_idx,
    input  logic                         nomatch_q,
    input  logic                         up_timeout,
    input  reply_t [NPORT-1:0]           dn_reply,
    input  logic [NPORT-1:0][DATA_W-1:0] dn_rdata_v,
    output reply_t                       cur_reply,
    output data_t                        up_rdata,
    output logic                         up_unknown_addr,
    output logic [NPORT-1:0]             dn_timeout
);

    data_t cur_data;

    always_comb begin
        cur_reply = '0;
        cur_data  = '0;
        if (pend_valid) begin
            cur_reply = dn_reply[pend_idx];
            cur_data  = dn_rdata_v[pend_idx];
        end
    end

    assign up_rdata        = cur_reply.dataready ? cur_data : '0;
    assign up_unknown_addr = nomatch_q | cur_reply.unknown_addr;

    genvar g;
    for (g = 0; g < NPORT; g++) begin : g_tmo
        assign dn_timeout[g] = up_timeout & pend_valid & (pend_idx == IDX_W'(g));
    end

endmodule

// File: rtl/regbus_split.sv
module regbus_split
    import regbus_split_pkg::*;
#(
    parameter int NPORT = 3,
    parameter logic [NPORT-1:0][ADDR_W-1:0]  PORT_BASE = {16'hA000, 16'h8000, 16'hA000},
    parameter logic [NPORT-1:0][MASKW_W-1:0] PORT_MW   = {5'd8, 5'd6, 5'd4}
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      up_rd,
    input  logic                      up_wr,
    input  logic [ADDR_W-1:0]         up_addr,
    input  logic [DATA_W-1:0]         up_wdata,
    input  logic                      up_timeout,
    output logic [DATA_W-1:0]         up_rdata,
    output logic                      up_dataready,
    output logic                      up_write_ack,
    output logic                      up_no_more_data,
    output logic                      up_unknown_addr,
    output logic [NPORT-1:0]          dn_rd,
    output logic [NPORT-1:0]          dn_wr,
    output logic [NPORT*ADDR_W-1:0]   dn_addr,
    output logic [NPORT*DATA_W-1:0]   dn_wdata,
    output logic [NPORT-1:0]          dn_timeout,
    input  logic [NPORT*DATA_W-1:0]   dn_rdata,
    input  logic [NPORT-1:0]          dn_dataready,
    input  logic [NPORT-1:0]          dn_write_ack,
    input  logic [NPORT-1:0]          dn_no_more_data,
    input  logic [NPORT-1:0]          dn_unknown_addr
);

    localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic                         strobe;
    logic [NPORT-1:0]             hit_onehot;
    logic [IDX_W-1:0]             hit_idx;
    logic                         any_hit;
    logic                         pend_valid;
    logic [IDX_W-1:0]             pend_idx;
    logic                         nomatch_q;
    reply_t                       cur_reply;
    reply_t [NPORT-1:0]           reply_v;
    logic [NPORT-1:0][DATA_W-1:0] rdata_v;

    assign strobe = up_rd | up_wr;

    regbus_split_decode #(
        .NPORT     (NPORT),
        .IDX_W     (IDX_W),
        .PORT_BASE (PORT_BASE),
        .PORT_MW   (PORT_MW)
    ) u_decode (
        .addr       (up_addr),
        .hit_onehot (hit_onehot),
        .hit_idx    (hit_idx),
        .any_hit    (any_hit)
    );

    genvar g;
    for (g = 0; g < NPORT; g++) begin : g_port
        logic fwd;
        assign fwd      = strobe & hit_onehot[g];
        assign dn_rd[g] = up_rd & hit_onehot[g];
        assign dn_wr[g] = up_wr & hit_onehot[g];
        assign dn_addr [g*ADDR_W +: ADDR_W] = fwd ? up_addr  : '0;
        assign dn_wdata[g*DATA_W +: DATA_W] = fwd ? up_wdata : '0;
        assign reply_v[g] = '{dataready:    dn_dataready[g],
                              write_ack:    dn_write_ack[g],
                              no_more_data: dn_no_more_data[g],
                              unknown_addr: dn_unknown_addr[g]};
        assign rdata_v[g] = dn_rdata[g*DATA_W +: DATA_W];
    end

    regbus_split_track #(
        .IDX_W (IDX_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .any_hit    (any_hit),
        .hit_idx    (hit_idx),
        .cur_reply  (cur_reply),
        .up_timeout (up_timeout),
        .pend_valid (pend_valid),
        .pend_idx   (pend_idx),
        .nomatch_q  (nomatch_q)
    );

    regbus_split_route #(
        .NPORT (NPORT),
        .IDX_W (IDX_W)
    ) u_route (
        .pend_valid      (pend_valid),
        .pend_idx        (pend_idx),
        .nomatch_q       (nomatch_q),
        .up_timeout      (up_timeout),
        .dn_reply        (reply_v),
        .dn_rdata_v      (rdata_v),
        .cur_reply       (cur_reply),
        .up_rdata        (up_rdata),
        .up_unknown_addr (up_unknown_addr),
        .dn_timeout      (dn_timeout)
    );

    assign up_dataready    = cur_reply.dataready;
    assign up_write_ack    = cur_reply.write_ack;
    assign up_no_more_data = cur_reply.no_more_data;

    // R2: a strobe never reaches more than one port
    p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_rd | dn_wr));

    // R4: an address outside every window is refused in the next cycle
    p_refuse_next_r4: assert property (@(posedge clk) disable iff (rst)
        strobe && (dn_rd == '0) && (dn_wr == '0) |=> up_unknown_addr);

    // R6: with nothing outstanding the upstream side stays silent
    p_idle_silent_r6: assert property (@(posedge clk) disable iff (rst)
        !pend_valid && !nomatch_q
        |-> !(up_dataready || up_write_ack || up_no_more_data || up_unknown_addr));

    // R9: read data is zero outside dataready
    p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !up_dataready |-> up_rdata == '0);

endmodule

// File: tb/regbus_split_bench.sv
module regbus_split_bench;

    localparam int CLK_PER = 10;
    localparam int NP      = 3;
    localparam logic [15:0] BASE [NP] = '{16'hA000, 16'h8000, 16'hA000};
    localparam int          MW   [NP] = '{4, 6, 8};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_rd = 1'b0, up_wr = 1'b0, up_timeout = 1'b0;
    logic [15:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic [31:0] up_rdata;
    logic up_dataready, up_write_ack, up_no_more_data, up_unknown_addr;
    logic [NP-1:0] dn_rd, dn_wr, dn_timeout;
    logic [NP*16-1:0] dn_addr;
    logic [NP*32-1:0] dn_wdata;
    logic [NP*32-1:0] dn_rdata = '0;
    logic [NP-1:0] dn_dataready = '0, dn_write_ack = '0, dn_no_more_data = '0, dn_unknown_addr = '0;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R10";
    int m_pend = -1;
    bit m_nom  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    regbus_split u_regbus_split (
        .clk(clk), .rst(rst),
        .up_rd(up_rd), .up_wr(up_wr), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_timeout(up_timeout), .up_rdata(up_rdata), .up_dataready(up_dataready),
        .up_write_ack(up_write_ack), .up_no_more_data(up_no_more_data),
        .up_unknown_addr(up_unknown_addr),
        .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_timeout(dn_timeout), .dn_rdata(dn_rdata), .dn_dataready(dn_dataready),
        .dn_write_ack(dn_write_ack), .dn_no_more_data(dn_no_more_data),
        .dn_unknown_addr(dn_unknown_addr)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (phase %s): got %h expected %h", req, what, phase, act, exp);
        end
    endtask

    function automatic int pick(logic [15:0] a);
        for (int i = 0; i < NP; i++)
            if ((a >> MW[i]) == (BASE[i] >> MW[i])) return i;
        return -1;
    endfunction

    function automatic bit any_reply(int p);
        return dn_dataready[p] | dn_write_ack[p] | dn_no_more_data[p] | dn_unknown_addr[p];
    endfunction

    // behavioural reference state, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_pend = -1;
            m_nom  = 1'b0;
        end else if (up_rd | up_wr) begin
            m_pend = pick(up_addr);
            m_nom  = (m_pend < 0);
        end else begin
            m_nom = 1'b0;
            if (m_pend >= 0 && (any_reply(m_pend) || up_timeout)) m_pend = -1;
        end
    end

    // full comparison on every falling edge
    always @(negedge clk) begin
        int  sel;
        bit  stb;
        bit  e_dr, e_wa, e_nm, e_ua;
        logic [31:0] e_rd;
        sel  = pick(up_addr);
        stb  = up_rd | up_wr;
        e_dr = (m_pend >= 0) && dn_dataready[m_pend];
        e_wa = (m_pend >= 0) && dn_write_ack[m_pend];
        e_nm = (m_pend >= 0) && dn_no_more_data[m_pend];
        e_ua = m_nom || ((m_pend >= 0) && dn_unknown_addr[m_pend]);
        e_rd = e_dr ? dn_rdata[m_pend*32 +: 32] : 32'h0;
        for (int p = 0; p < NP; p++) begin
            chk("R2", $sformatf("dn_rd[%0d]", p), 32'(dn_rd[p]), 32'(up_rd && sel == p));
            chk("R2", $sformatf("dn_wr[%0d]", p), 32'(dn_wr[p]), 32'(up_wr && sel == p));
            chk("R2", $sformatf("dn_addr[%0d]", p), 32'(dn_addr[p*16 +: 16]),
                (stb && sel == p) ? 32'(up_addr) : 32'h0);
            chk("R2", $sformatf("dn_wdata[%0d]", p), dn_wdata[p*32 +: 32],
                (stb && sel == p) ? up_wdata : 32'h0);
            chk("R8", $sformatf("dn_timeout[%0d]", p), 32'(dn_timeout[p]),
                32'(up_timeout && m_pend == p));
        end
        chk("R5", "up_dataready", 32'(up_dataready), 32'(e_dr));
        chk("R5", "up_write_ack", 32'(up_write_ack), 32'(e_wa));
        chk("R5", "up_no_more_data", 32'(up_no_more_data), 32'(e_nm));
        chk("R4", "up_unknown_addr", 32'(up_unknown_addr), 32'(e_ua));
        chk("R9", "up_rdata", up_rdata, e_rd);
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        up_rd = 0; up_wr = 0; up_timeout = 0; up_addr = '0; up_wdata = '0;
        dn_dataready = '0; dn_write_ack = '0; dn_no_more_data = '0; dn_unknown_addr = '0;
        dn_rdata = '0;
    endtask

    // one strobe cycle, then check which port took it
    task automatic strobe_to(bit wr, logic [15:0] a, logic [NP-1:0] exp_port, string req);
        step();
        quiet();
        up_rd = !wr; up_wr = wr; up_addr = a; up_wdata = 32'hC0DE_0000 | 32'(a);
        #2;
        chk(req, $sformatf("target of %h", a), 32'(dn_rd | dn_wr), 32'(exp_port));
        step();
        quiet();
    endtask

    initial begin
        quiet();
        rst = 1'b1;
        repeat (3) step();
        #2;
        phase = "R10";
        chk("R10", "reset replies", {28'h0, up_dataready, up_write_ack, up_no_more_data, up_unknown_addr}, 32'h0);
        chk("R10", "reset rdata", up_rdata, 32'h0);
        step();
        rst = 1'b0;

        phase = "R1";
        strobe_to(0, 16'h8000, 3'b010, "R1");
        strobe_to(0, 16'h803F, 3'b010, "R1");
        strobe_to(1, 16'hA0FF, 3'b100, "R1");
        strobe_to(0, 16'h8040, 3'b000, "R1");
        #2 chk("R4", "refusal after 0x8040", 32'(up_unknown_addr), 32'h1);
        step();
        #2 chk("R4", "refusal is one cycle", 32'(up_unknown_addr), 32'h0);
        strobe_to(1, 16'hA100, 3'b000, "R4");

        phase = "R3";
        strobe_to(0, 16'hA005, 3'b001, "R3");
        strobe_to(0, 16'hA0F0, 3'b100, "R3");

        phase = "R5";
        strobe_to(0, 16'h8010, 3'b010, "R5");
        dn_dataready = 3'b001; dn_rdata[31:0] = 32'hBAD0_0001;
        #2 chk("R6", "other port reply ignored", 32'(up_dataready), 32'h0);
        chk("R6", "other port data ignored", up_rdata, 32'h0);
        step();
        quiet();
        dn_dataready = 3'b010; dn_rdata[63:32] = 32'h1234_5678;
        #2 chk("R5", "owner dataready", 32'(up_dataready), 32'h1);
        chk("R9", "owner rdata", up_rdata, 32'h1234_5678);
        step();
        quiet();
        dn_dataready = 3'b010; dn_rdata[63:32] = 32'h5555_AAAA;
        #2 chk("R7", "reply after close ignored", 32'(up_dataready), 32'h0);
        chk("R7", "data after close ignored", up_rdata, 32'h0);

        phase = "R8";
        strobe_to(1, 16'hA003, 3'b001, "R8");
        up_timeout = 1'b1;
        #2 chk("R8", "timeout to owner", 32'(dn_timeout), 32'h1);
        step();
        quiet();
        dn_write_ack = 3'b001;
        #2 chk("R7", "ack after timeout ignored", 32'(up_write_ack), 32'h0);
        step();
        quiet();
        up_timeout = 1'b1;
        #2 chk("R8", "idle timeout reaches no port", 32'(dn_timeout), 32'h0);
        step();
        quiet();

        phase = "R7";
        strobe_to(0, 16'h8001, 3'b010, "R7");
        strobe_to(1, 16'hA0C0, 3'b100, "R7");
        dn_no_more_data = 3'b110;
        #2 chk("R7", "new strobe took ownership", 32'(up_no_more_data), 32'h1);
        step();
        quiet();

        phase = "R6";
        for (int c = 0; c < 4000; c++) begin
            logic [15:0] pool [8];
            int r;
            pool = '{16'h8000, 16'h803F, 16'h8040, 16'hA000, 16'hA00F, 16'hA010, 16'hA0FF, 16'hA100};
            step();
            quiet();
            r = $urandom_range(0, 7);
            if (r == 0) begin
                up_rd = 1'b1;
            end else if (r == 1) begin
                up_wr = 1'b1;
            end
            up_addr  = ($urandom_range(0, 3) == 0) ? 16'($urandom) : pool[$urandom_range(0, 7)];
            up_wdata = $urandom;
            up_timeout = ($urandom_range(0, 15) == 0);
            for (int p = 0; p < NP; p++) begin
                dn_dataready[p]    = ($urandom_range(0, 5) == 0);
                dn_write_ack[p]    = ($urandom_range(0, 7) == 0);
                dn_no_more_data[p] = ($urandom_range(0, 11) == 0);
                dn_unknown_addr[p] = ($urandom_range(0, 13) == 0);
                dn_rdata[p*32 +: 32] = $urandom;
            end
        end
        step();
        quiet();
        repeat (2) step();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running expected finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule